// File: doc/BRIEF.md
# Metaframe Frame Synchronizer

This block sits on the receive path of a lane that carries 67-bit coded blocks in fixed-length metaframes. An upstream stage has already found the block boundaries and reports this on `blk_aligned`. The synchronizer looks for the synchronization control word and uses it to set position zero. It then counts block positions through each metaframe and runs a four-state lock machine (RESET, SEARCH, VERIFY, LOCKED). It reports the following:

- a pulse at each metaframe start
- a frame-lock level
- a per-metaframe structure error
- a sync-word error level
- two flags for SKIP words that are misplaced or missing

The metaframe has a fixed order:

- position 0: synchronization word
- position 1: scrambler-state word
- positions 2 to `SKIP_N`+1: SKIP words
- following positions: payload
- last position: diagnostic word

The length `MF_LEN` and the lock thresholds are parameters. Descrambling, CRC checking, deskew and the block-lock search are done elsewhere.

Top module: `ilkn_mframe_sync`

## Requirements
- R1: Block coding is as follows. Bits [65:64] are the header: `10` marks a control word, `01` a data word, and `00`/`11` are invalid. Bits [63:58] carry the control type: 0x1E sync, 0x0A scrambler state, 0x07 SKIP, 0x19 diagnostic. A sync word is a control word whose bits [63:0] equal 64'h78F6_78F6_78F6_78F6. Bit 66 is ignored.
- R2: While `rst_n` is low, and on the cycle after it, every output is 0. The machine leaves RESET for SEARCH on the first clock after reset.
- R3: In SEARCH, the first accepted sync word becomes position 0, and `mframe_sop` pulses on the cycle after it. In VERIFY and LOCKED, `mframe_sop` pulses on the cycle after every accepted block at position 0. Without a sync word, SEARCH gives no pulse.
- R4: `fr_locked` rises on the cycle after the 4th consecutive sync word accepted at `MF_LEN`-block spacing.
- R5: In VERIFY, a non-sync block at position 0 returns the machine to SEARCH. The count of good sync words restarts.
- R6: In VERIFY and LOCKED, `sync_word_err` is a level. It is reloaded at each position-0 block: 1 if that block is not a sync word, 0 if it is.
- R7: In LOCKED, 4 consecutive bad sync words drop `fr_locked` on the cycle after the 4th. A good sync word clears the count.
- R8: In LOCKED, `mframe_err` pulses on the cycle after the last block of a metaframe if any of the following occurred in that metaframe:
  - a wrong word at position 1
  - a wrong word at the last position
  - a sync-type control word away from position 0
  - an invalid header

  Three consecutive such metaframes drop lock.
- R9: In LOCKED, a SKIP word at a position that is not a SKIP position pulses `skip_misplaced` on the next cycle.
- R10: In LOCKED, a non-SKIP block at a SKIP position pulses `skip_missing` on the next cycle.
- R11: While `blk_aligned` is low, the following hold:
  - blocks are ignored
  - the next cycle shows SEARCH with `fr_locked` = 0
  - `sync_word_err` is 1 and stays 1

  After `blk_aligned` returns, `sync_word_err` stays at 1 until the next position-0 evaluation in VERIFY or LOCKED.
- R12: Cycles with `blk_valid` low do not advance the position and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | 1 | A block is present this cycle |
| blk_data | input | 67 | Coded block, header in [65:64] |
| blk_aligned | input | 1 | Upstream block boundary is locked |
| mframe_sop | output | 1 | Pulse: a metaframe began on the previous block |
| fr_locked | output | 1 | Frame lock achieved |
| mframe_err | output | 1 | Pulse: the metaframe that just ended had a structure error |
| sync_word_err | output | 1 | Level: the last sync evaluation failed, or block lock is lost |
| skip_misplaced | output | 1 | Pulse: SKIP word outside the SKIP positions |
| skip_missing | output | 1 | Pulse: non-SKIP word at a SKIP position |

## Verification
The bench builds the block with `MF_LEN` = 8 and `SKIP_N` = 2, keeping the default thresholds of 4, 4 and 3. These values keep each metaframe short enough to step through every position. They also let the bench fill every threshold: four-metaframe lock acquisition, four bad sync words and three bad metaframes. Each metaframe is generated with one chosen defect, so every flag is seen both firing and staying quiet. The bench also places idle cycles inside metaframes and drops block lock part-way through a locked stream.

// File: rtl/ilkn_fs_pkg.sv
package ilkn_fs_pkg;

  typedef enum logic [1:0] {
    FS_RESET  = 2'd0,
    FS_SEARCH = 2'd1,
    FS_VERIFY = 2'd2,
    FS_LOCKED = 2'd3
  } fs_state_e;

  localparam logic [1:0]  HDR_CTRL  = 2'b10;
  localparam logic [63:0] SYNC_WORD = 64'h78F6_78F6_78F6_78F6;
  localparam logic [5:0]  TY_SYNC   = SYNC_WORD[63:58];
  localparam logic [5:0]  TY_SCR    = 6'h0A;
  localparam logic [5:0]  TY_SKIP   = 6'h07;
  localparam logic [5:0]  TY_DIAG   = 6'h19;

  typedef struct packed {
    logic hdr_bad;
    logic is_sync;
    logic sync_type;
    logic is_scr;
    logic is_skip;
    logic is_diag;
  } blk_cls_t;

  // Decode one coded block; bit 66 carries no meaning here.
  function automatic blk_cls_t classify(input logic [66:0] d);
    blk_cls_t c;
    logic ctl;
    ctl         = (d[65:64] == HDR_CTRL);
    c.hdr_bad   = (d[65] == d[64]);
    c.is_sync   = ctl && (d[63:0] == SYNC_WORD);
    c.sync_type = ctl && (d[63:58] == TY_SYNC);
    c.is_scr    = ctl && (d[63:58] == TY_SCR);
    c.is_skip   = ctl && (d[63:58] == TY_SKIP);
    c.is_diag   = ctl && (d[63:58] == TY_DIAG);
    return c;
  endfunction

  // SKIP slots follow the scrambler-state word.
  function automatic logic is_skip_slot(input int pos, input int skip_n);
    return (pos >= 2) && (pos < 2 + skip_n);
  endfunction

endpackage

// File: rtl/ilkn_fs_decode.sv
module ilkn_fs_decode
  import ilkn_fs_pkg::*;
(
  input  logic [66:0] blk_data,
  output blk_cls_t    cls
);
  assign cls = classify(blk_data);
endmodule

// File: rtl/ilkn_fs_position.sv
module ilkn_fs_position
  import ilkn_fs_pkg::*;
#(
  parameter int MF_LEN = 16,
  parameter int SKIP_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic load_one,
  input  logic advance,
  output logic at_first,
  output logic at_scr,
  output logic at_skip,
  output logic at_last
);
  localparam int PW = (MF_LEN > 1) ? $clog2(MF_LEN) : 1;
  localparam logic [PW-1:0] LAST = PW'(MF_LEN - 1);

  logic [PW-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      pos_q <= '0;
    end else if (load_one) begin
      pos_q <= PW'(1);
    end else if (advance) begin
      pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
    end
  end

  assign at_first = (pos_q == '0);
  assign at_scr   = (pos_q == PW'(1));
  assign at_skip  = is_skip_slot(int'(pos_q), SKIP_N);
  assign at_last  = (pos_q == LAST);
endmodule

// File: rtl/ilkn_fs_ctrl.sv
module ilkn_fs_ctrl
  import ilkn_fs_pkg::*;
#(
  parameter int LOCK_GOOD = 4,
  parameter int LOSE_BAD  = 4,
  parameter int LOSE_MF   = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      blk_valid,
  input  logic      blk_aligned,
  input  blk_cls_t  cls,
  input  logic      at_first,
  input  logic      at_scr,
  input  logic      at_last,
  output fs_state_e state_q,
  output logic      search_hit,
  output logic      advance,
  output logic      sync_chk,
  output logic      locked_take,
  output logic      mf_close_bad
);
  localparam int GW = $clog2(LOCK_GOOD + 1);
  localparam int BW = $clog2(LOSE_BAD + 1);
  localparam int MW = $clog2(LOSE_MF + 1);

  logic [GW-1:0] good_q;
  logic [BW-1:0] bad_q;
  logic [MW-1:0] mfrun_q;
  logic          acc_q;
  logic          take, framed, struct_bad, mf_close;

  assign take        = blk_valid && blk_aligned;
  assign framed      = (state_q == FS_VERIFY) || (state_q == FS_LOCKED);
  assign search_hit  = take && (state_q == FS_SEARCH) && cls.is_sync;
  assign advance     = take && framed;
  assign sync_chk    = advance && at_first;
  assign locked_take = take && (state_q == FS_LOCKED);
  assign struct_bad  = cls.hdr_bad || (at_scr && !cls.is_scr) ||
                       (at_last && !cls.is_diag) || (!at_first && cls.sync_type);
  assign mf_close     = locked_take && at_last;
  assign mf_close_bad = mf_close && (acc_q || struct_bad);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FS_RESET;
      good_q  <= '0;
      bad_q   <= '0;
      mfrun_q <= '0;
      acc_q   <= 1'b0;
    end else if (!blk_aligned) begin
      state_q <= FS_SEARCH;
      good_q  <= '0;
      bad_q   <= '0;
      mfrun_q <= '0;
      acc_q   <= 1'b0;
    end else begin
      if (advance) acc_q <= at_first ? 1'b0 : (acc_q || struct_bad);
      unique case (state_q)
        FS_RESET: state_q <= FS_SEARCH;
        FS_SEARCH: if (search_hit) begin
          state_q <= FS_VERIFY;
          good_q  <= GW'(1);
        end
        FS_VERIFY: if (sync_chk) begin
          if (!cls.is_sync) begin
            state_q <= FS_SEARCH;
            good_q  <= '0;
          end else if (good_q == GW'(LOCK_GOOD - 1)) begin
            state_q <= FS_LOCKED;
            bad_q   <= '0;
            mfrun_q <= '0;
          end else begin
            good_q <= good_q + 1'b1;
          end
        end
        FS_LOCKED: begin
          if (sync_chk) begin
            if (cls.is_sync) bad_q <= '0;
            else if (bad_q == BW'(LOSE_BAD - 1)) state_q <= FS_SEARCH;
            else bad_q <= bad_q + 1'b1;
          end
          if (mf_close) begin
            if (!mf_close_bad) mfrun_q <= '0;
            else if (mfrun_q == MW'(LOSE_MF - 1)) state_q <= FS_SEARCH;
            else mfrun_q <= mfrun_q + 1'b1;
          end
        end
        default: state_q <= FS_RESET;
      endcase
    end
  end
endmodule

// File: rtl/ilkn_mframe_sync.sv
module ilkn_mframe_sync
  import ilkn_fs_pkg::*;
#(
  parameter int MF_LEN    = 16,
  parameter int SKIP_N    = 2,
  parameter int LOCK_GOOD = 4,
  parameter int LOSE_BAD  = 4,
  parameter int LOSE_MF   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        blk_valid,
  input  logic [66:0] blk_data,
  input  logic        blk_aligned,
  output logic        mframe_sop,
  output logic        fr_locked,
  output logic        mframe_err,
  output logic        sync_word_err,
  output logic        skip_misplaced,
  output logic        skip_missing
);
  blk_cls_t  cls_w;
  fs_state_e state_w;
  logic at_first_w, at_scr_w, at_skip_w, at_last_w;
  logic search_hit_w, advance_w, sync_chk_w, locked_take_w, mf_close_bad_w;

  ilkn_fs_decode u_dec (.blk_data(blk_data), .cls(cls_w));

  ilkn_fs_position #(.MF_LEN(MF_LEN), .SKIP_N(SKIP_N)) u_pos (
    .clk(clk), .rst_n(rst_n), .clear(!blk_aligned),
    .load_one(search_hit_w), .advance(advance_w),
    .at_first(at_first_w), .at_scr(at_scr_w),
    .at_skip(at_skip_w), .at_last(at_last_w)
  );

  ilkn_fs_ctrl #(.LOCK_GOOD(LOCK_GOOD), .LOSE_BAD(LOSE_BAD), .LOSE_MF(LOSE_MF)) u_ctl (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_aligned(blk_aligned),
    .cls(cls_w), .at_first(at_first_w), .at_scr(at_scr_w), .at_last(at_last_w),
    .state_q(state_w), .search_hit(search_hit_w), .advance(advance_w),
    .sync_chk(sync_chk_w), .locked_take(locked_take_w), .mf_close_bad(mf_close_bad_w)
  );

  assign fr_locked = (state_w == FS_LOCKED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mframe_sop     <= 1'b0;
      mframe_err     <= 1'b0;
      sync_word_err  <= 1'b0;
      skip_misplaced <= 1'b0;
      skip_missing   <= 1'b0;
    end else begin
      mframe_sop     <= search_hit_w || sync_chk_w;
      mframe_err     <= mf_close_bad_w;
      skip_misplaced <= locked_take_w && cls_w.is_skip && !at_skip_w;
      skip_missing   <= locked_take_w && at_skip_w && !cls_w.is_skip;
      if (!blk_aligned) sync_word_err <= 1'b1;
      else if (sync_chk_w) sync_word_err <= !cls_w.is_sync;
    end
  end
endmodule

// File: rtl/ilkn_fs_chk.sv
module ilkn_fs_chk
  import ilkn_fs_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        blk_valid,
  input logic [66:0] blk_data,
  input logic        blk_aligned,
  input logic        mframe_sop,
  input logic        fr_locked,
  input logic        mframe_err,
  input logic        sync_word_err,
  input logic        skip_misplaced,
  input logic        skip_missing,
  input logic        at_first,
  input logic        at_last
);
  p_lock_on_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fr_locked) |-> $past(blk_valid && blk_aligned &&
      blk_data[65:64] == HDR_CTRL && blk_data[63:0] == SYNC_WORD));

  p_align_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_aligned |=> (!fr_locked && sync_word_err));

  p_skip_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(skip_misplaced && skip_missing));

  p_flags_need_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mframe_err || skip_misplaced || skip_missing) |-> $past(fr_locked));

  p_mferr_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mframe_err |-> $past(blk_valid && at_last));

  p_sop_at_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mframe_sop |-> $past(blk_valid && blk_aligned && (at_first || !fr_locked)));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_valid && blk_aligned) |=>
      (!mframe_sop && !mframe_err && !skip_misplaced && !skip_missing));

  p_idle_lock_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_valid && blk_aligned && fr_locked) |=> fr_locked);
endmodule

bind ilkn_mframe_sync ilkn_fs_chk u_fs_chk (
  .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_data(blk_data),
  .blk_aligned(blk_aligned), .mframe_sop(mframe_sop), .fr_locked(fr_locked),
  .mframe_err(mframe_err), .sync_word_err(sync_word_err),
  .skip_misplaced(skip_misplaced), .skip_missing(skip_missing),
  .at_first(at_first_w), .at_last(at_last_w)
);

// File: tb/ilkn_mframe_sync_tb_top.sv
module ilkn_mframe_sync_tb_top;
  localparam int MFL = 8;
  localparam int SKN = 2;
  localparam logic [63:0] SYNC = 64'h78F6_78F6_78F6_78F6;

  typedef enum int {K_CLEAN, K_BADSYNC, K_SKIPX, K_SKIPM, K_BADDIAG, K_INV66, K_HDR01} kind_e;

  logic clk = 1'b0, rst_n = 1'b0, blk_valid = 1'b0, blk_aligned = 1'b1;
  logic [66:0] blk_data = '0;
  logic mframe_sop, fr_locked, mframe_err, sync_word_err, skip_misplaced, skip_missing;

  int n_cmp = 0, n_bad = 0;
  int n_start, n_skip, n_pyld, n_mferr;
  logic o_start0, o_lock0, o_serr0, o_mferr_last, o_lock_end, o_serr_end;

  always #5 clk = ~clk;

  ilkn_mframe_sync #(.MF_LEN(MFL), .SKIP_N(SKN)) dut_i (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_data(blk_data),
    .blk_aligned(blk_aligned), .mframe_sop(mframe_sop), .fr_locked(fr_locked),
    .mframe_err(mframe_err), .sync_word_err(sync_word_err),
    .skip_misplaced(skip_misplaced), .skip_missing(skip_missing)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [66:0] ctl_w(input logic [5:0] ty, input logic [57:0] rest);
    return {1'b0, 2'b10, ty, rest};
  endfunction

  function automatic logic [66:0] dat_w(input int p);
    return {1'b0, 2'b01, 64'hA5A5_0000_0000_0000 | 64'(p)};
  endfunction

  function automatic logic [66:0] word(input int p, input kind_e k);
    logic [66:0] w;
    if (p == 0) w = {1'b0, 2'b10, SYNC};
    else if (p == 1) w = ctl_w(6'h0A, 58'h123);
    else if (p >= 2 && p < 2 + SKN) w = ctl_w(6'h07, 58'h0);
    else if (p == MFL - 1) w = ctl_w(6'h19, 58'h3C);
    else w = dat_w(p);
    case (k)
      K_BADSYNC: if (p == 0) w = dat_w(0);
      K_SKIPX:   if (p == MFL - 2) w = ctl_w(6'h07, 58'h0);
      K_SKIPM:   if (p == 1 + SKN) w = dat_w(p);
      K_BADDIAG: if (p == MFL - 1) w = dat_w(p);
      K_INV66:   w[66] = 1'b1;
      K_HDR01:   if (p == 0) w = {1'b0, 2'b01, SYNC};
      default: ;
    endcase
    return w;
  endfunction

  task automatic drive(input logic v, input logic [66:0] d);
    @(negedge clk);
    blk_valid = v;
    blk_data  = d;
    @(posedge clk);
    #1;
  endtask

  task automatic tally();
    n_start += int'(mframe_sop);
    n_skip  += int'(skip_misplaced);
    n_pyld  += int'(skip_missing);
    n_mferr += int'(mframe_err);
  endtask

  task automatic send_mf(input kind_e k, input bit gap);
    n_start = 0; n_skip = 0; n_pyld = 0; n_mferr = 0;
    for (int p = 0; p < MFL; p++) begin
      drive(1'b1, word(p, k));
      tally();
      if (p == 0) begin
        o_start0 = mframe_sop; o_lock0 = fr_locked; o_serr0 = sync_word_err;
      end
      if (p == MFL - 1) begin
        o_mferr_last = mframe_err; o_lock_end = fr_locked; o_serr_end = sync_word_err;
      end
      if (gap) begin
        drive(1'b0, '0);
        tally();
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 reset outputs", int'({mframe_sop, fr_locked, mframe_err, sync_word_err,
                                    skip_misplaced, skip_missing}), 0);
    rst_n = 1'b1;
    drive(1'b0, '0);
    check("R2 after reset", int'({mframe_sop, fr_locked, sync_word_err}), 0);

    // R3: no sync, no start
    n_start = 0;
    for (int i = 0; i < 3; i++) begin drive(1'b1, dat_w(i)); tally(); end
    check("R3 no sop without sync", n_start, 0);

    // R4 / R12 acquisition, last metaframes with idle gaps
    send_mf(K_CLEAN, 1'b0);
    check("R3 sop on first sync", int'(o_start0), 1);
    check("R3 one sop per metaframe", n_start, 1);
    send_mf(K_CLEAN, 1'b0);
    send_mf(K_CLEAN, 1'b1);
    check("R4 not locked after 3rd sync", int'(o_lock0), 0);
    check("R12 idle does not add sop", n_start, 1);
    send_mf(K_CLEAN, 1'b1);
    check("R4 locked after 4th sync", int'(o_lock0), 1);
    check("R12 sop with gaps", int'(o_start0), 1);

    // R9 / R10 SKIP placement
    send_mf(K_SKIPX, 1'b0);
    check("R9 misplaced skip", n_skip, 1);
    check("R10 no missing flag on misplaced", n_pyld, 0);
    send_mf(K_SKIPM, 1'b0);
    check("R10 missing skip", n_pyld, 1);
    check("R9 no misplaced flag on missing", n_skip, 0);
    send_mf(K_CLEAN, 1'b0);
    check("R9 clean no flags", n_skip + n_pyld + n_mferr, 0);

    // R8 metaframe errors
    send_mf(K_BADDIAG, 1'b0);
    check("R8 mframe_err at end", int'(o_mferr_last), 1);
    send_mf(K_CLEAN, 1'b0);
    check("R8 clean metaframe no error", n_mferr, 0);
    send_mf(K_BADDIAG, 1'b0);
    send_mf(K_BADDIAG, 1'b0);
    check("R8 lock kept after 2 bad", int'(o_lock_end), 1);
    send_mf(K_BADDIAG, 1'b0);
    check("R8 lock lost after 3 bad", int'(o_lock_end), 0);

    // R1 header / bit 66
    send_mf(K_HDR01, 1'b0);
    check("R1 data header not sync", n_start, 0);
    for (int i = 0; i < 4; i++) send_mf(K_INV66, 1'b0);
    check("R1 bit 66 ignored, lock", int'(o_lock0), 1);

    // R6 / R7 sync errors
    send_mf(K_BADSYNC, 1'b0);
    check("R6 sync err set", int'(o_serr0), 1);
    check("R6 still locked", int'(o_lock_end), 1);
    check("R6 bad sync not a mframe error", n_mferr, 0);
    send_mf(K_CLEAN, 1'b0);
    check("R6 sync err cleared", int'(o_serr0), 0);
    for (int i = 0; i < 3; i++) send_mf(K_BADSYNC, 1'b0);
    send_mf(K_CLEAN, 1'b0);
    send_mf(K_BADSYNC, 1'b0);
    check("R7 good sync resets count", int'(o_lock_end), 1);
    send_mf(K_BADSYNC, 1'b0);
    send_mf(K_BADSYNC, 1'b0);
    check("R7 locked after 3 bad", int'(o_lock0), 1);
    send_mf(K_BADSYNC, 1'b0);
    check("R7 lost after 4 bad", int'(o_lock0), 0);

    // R5 verify failure
    send_mf(K_CLEAN, 1'b0);
    send_mf(K_BADSYNC, 1'b0);
    check("R5 verify bad sync flags", int'(o_serr0), 1);
    send_mf(K_CLEAN, 1'b0);
    send_mf(K_CLEAN, 1'b0);
    send_mf(K_CLEAN, 1'b0);
    check("R5 count restarted", int'(o_lock0), 0);
    send_mf(K_CLEAN, 1'b0);
    check("R5 lock after fresh 4", int'(o_lock0), 1);

    // R11 block alignment loss
    @(negedge clk);
    blk_aligned = 1'b0;
    drive(1'b0, '0);
    check("R11 lock cleared", int'(fr_locked), 0);
    check("R11 sync err forced", int'(sync_word_err), 1);
    send_mf(K_CLEAN, 1'b0);
    check("R11 blocks ignored", n_start, 0);
    check("R11 sync err held", int'(o_serr_end), 1);
    @(negedge clk);
    blk_aligned = 1'b1;
    send_mf(K_CLEAN, 1'b0);
    check("R11 search restarts", int'(o_start0), 1);
    check("R11 sync err held in search", int'(o_serr0), 1);
    send_mf(K_CLEAN, 1'b0);
    check("R11 sync err updates in verify", int'(o_serr0), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule